// File: doc/BRIEF.md
# Multi-Mode 16-Bit Timer Channel

One channel of a peripheral timer array. A 16-bit counter and a 16-bit reload value are loaded a byte at a time over an 8-bit write port. A two-bit mode field makes the same counter work in one of four ways. It can be a periodic down-counting timer, an event counter that counts up or down, a one-shot timer that stops itself, or a pulse-width modulator with a fixed 65536-tick period.

In timer, one-shot and PWM modes the counter advances on one of four prescaled clock enables, which are generated outside the block. In timer mode the external pin can gate counting. In event-counter mode the count source is one of these: edges on the synchronised external pin (rising or falling), the overflow pulse of the previous channel in the ring, the overflow pulse of the next channel, or the overflow of another timer group. Every wrap of the counter raises a one-cycle pulse and sets an interrupt request. The pulse output is a toggle flip-flop, or the PWM waveform in PWM mode.

Top module: `mtimer_chan`

## Requirements
- R1: After reset the counter, the reload value, the configuration and control bits, `ovf_pulse`, `irq` and `pulse_out` are all zero.
- R2: A write at address 0 sets the reload low byte and address 1 sets the reload high byte. Address 2 sets the configuration byte: bits [1:0] mode (00 timer, 01 event, 10 one-shot, 11 PWM), [3:2] clock enable select, [5:4] event source, [6] falling-edge select and [7] gate enable. Address 3 sets control: bit 0 start, bit 1 count up, and bit 2 writes 1 to clear `irq`. While start is 0, a reload byte write also loads the same byte of the counter.
- R3: While start is 0 and no load is written, the counter holds its value.
- R4: In timer, one-shot and PWM modes the counter decrements by one on each cycle where `tick_en[csel]` is high and start is 1.
- R5: When counting down from 0x0000, or up from 0xFFFF, the counter takes the reload value (0xFFFF in PWM mode). `ovf_pulse` is high for that one following cycle, and `irq` is set until a control write with bit 2 set. A new wrap wins over the clear.
- R6: In timer mode with gate enable set, the counter advances only while the synchronised pin is high.
- R7: In event mode the source is chosen by bits [5:4]: 00 pin edges, 01 `prev_ovf`, 10 `next_ovf`, 11 `grp_ovf`, and `tick_en` is ignored. The pin passes through two synchronising flops. With bit 6 at 0 rising edges count; with bit 6 at 1 falling edges count.
- R8: In event mode, control bit 1 set makes the counter increment. When it increments from 0xFFFF it reloads and pulses.
- R9: In one-shot mode the wrap from 0x0000 also clears start, so the counter then holds the reload value.
- R10: Outside PWM mode `pulse_out` toggles once for each `ovf_pulse`.
- R11: In PWM mode, a control write that sets start from 0 loads the counter with 0xFFFF. `pulse_out` is high while start is 1 and (0xFFFF − count) is less than the reload value. The counter wraps from 0x0000 to 0xFFFF with `ovf_pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | 2 | Write address (0 reload low, 1 reload high, 2 config, 3 control) |
| wr_data | input | 8 | Write data |
| tick_en | input | 4 | Prescaled clock enables |
| pin_in | input | 1 | External pin input (asynchronous) |
| prev_ovf | input | 1 | Overflow pulse of the previous channel |
| next_ovf | input | 1 | Overflow pulse of the next channel |
| grp_ovf | input | 1 | Overflow pulse of the other timer group |
| count_val | output | 16 | Current counter value |
| ovf_pulse | output | 1 | One-cycle wrap pulse |
| irq | output | 1 | Interrupt request, held until cleared |
| pulse_out | output | 1 | Toggle or PWM output |

## Verification
The PWM wrap is the hardest case to reach from the ports, because it needs a full 65536-tick period. The stimulus arms PWM with the undivided enable and runs the whole period, so both the duty edge and the wrap to 0xFFFF are observed. The overflow case in event mode is reached by writing 0xFFFE into the stopped counter through the write-through path, so that two group pulses are enough to cross 0xFFFF. The one-shot self-stop and the `irq` set-versus-clear race are checked every clock against a behavioural model.

// File: rtl/mtc_pkg.sv
package mtc_pkg;
  parameter int CNT_W  = 16;
  parameter int BYTE_W = 8;
  parameter int N_CLK  = 4;

  typedef enum logic [1:0] {
    MD_TIMER   = 2'b00,
    MD_EVENT   = 2'b01,
    MD_ONESHOT = 2'b10,
    MD_PWM     = 2'b11
  } mode_e;

  typedef struct packed {
    logic       gate;
    logic       falling;
    logic [1:0] esel;
    logic [1:0] csel;
    mode_e      mode;
  } cfg_t;

  function automatic logic [CNT_W-1:0] f_dec(input logic [CNT_W-1:0] c);
    return c - CNT_W'(1);
  endfunction

  function automatic logic [CNT_W-1:0] f_inc(input logic [CNT_W-1:0] c);
    return c + CNT_W'(1);
  endfunction

  function automatic logic f_pwm_level(input logic [CNT_W-1:0] c,
                                       input logic [CNT_W-1:0] duty,
                                       input logic run);
    return run && ((~c) < duty);
  endfunction
endpackage

// File: rtl/mtc_regs.sv
module mtc_regs
  import mtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              stop_req,
  output cfg_t              cfg,
  output logic [CNT_W-1:0]  reload,
  output logic              start,
  output logic              up,
  output logic              irq_clr,
  output logic              ld_lo,
  output logic              ld_hi,
  output logic              ld_full
);
  localparam logic [1:0] A_RLO = 2'd0;
  localparam logic [1:0] A_RHI = 2'd1;
  localparam logic [1:0] A_CFG = 2'd2;
  localparam logic [1:0] A_CTL = 2'd3;

  logic wr_ctl;
  assign wr_ctl  = wr_en && (wr_addr == A_CTL);
  assign irq_clr = wr_ctl && wr_data[2];
  assign ld_lo   = wr_en && (wr_addr == A_RLO) && !start;
  assign ld_hi   = wr_en && (wr_addr == A_RHI) && !start;
  assign ld_full = wr_ctl && wr_data[0] && !start && (cfg.mode == MD_PWM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg    <= '0;
      reload <= '0;
      start  <= 1'b0;
      up     <= 1'b0;
    end else begin
      if (wr_en && wr_addr == A_RLO) reload[BYTE_W-1:0] <= wr_data;
      if (wr_en && wr_addr == A_RHI) reload[CNT_W-1:BYTE_W] <= wr_data;
      if (wr_en && wr_addr == A_CFG) cfg <= cfg_t'(wr_data);
      if (wr_ctl) begin
        start <= wr_data[0];
        up    <= wr_data[1];
      end else if (stop_req) begin
        start <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mtc_src.sv
module mtc_src
  import mtc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  cfg_t             cfg,
  input  logic [N_CLK-1:0] tick_en,
  input  logic             pin_in,
  input  logic             prev_ovf,
  input  logic             next_ovf,
  input  logic             grp_ovf,
  output logic             tick,
  output logic             pin_s
);
  logic s1, s2, pd;
  logic pin_rise, pin_fall, ev_tick, clk_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      pd <= 1'b0;
    end else begin
      s1 <= pin_in;
      s2 <= s1;
      pd <= s2;
    end
  end

  assign pin_s    = s2;
  assign pin_rise = s2 & ~pd;
  assign pin_fall = ~s2 & pd;

  always_comb begin
    case (cfg.esel)
      2'b00:   ev_tick = cfg.falling ? pin_fall : pin_rise;
      2'b01:   ev_tick = prev_ovf;
      2'b10:   ev_tick = next_ovf;
      default: ev_tick = grp_ovf;
    endcase
  end

  assign clk_tick = tick_en[cfg.csel] &&
                    ((cfg.mode != MD_TIMER) || !cfg.gate || pin_s);
  assign tick = (cfg.mode == MD_EVENT) ? ev_tick : clk_tick;

  AST_EVENT_IGNORES_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.mode == MD_EVENT && cfg.esel == 2'b01 && !prev_ovf) |-> !tick); // R7
endmodule

// File: rtl/mtc_core.sv
module mtc_core
  import mtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  cfg_t              cfg,
  input  logic [CNT_W-1:0]  reload,
  input  logic              start,
  input  logic              up,
  input  logic              tick,
  input  logic              irq_clr,
  input  logic              ld_lo,
  input  logic              ld_hi,
  input  logic              ld_full,
  input  logic [BYTE_W-1:0] ld_byte,
  output logic [CNT_W-1:0]  count,
  output logic              ovf,
  output logic              irq,
  output logic              pulse_out,
  output logic              stop_req,
  output logic              active
);
  localparam logic [CNT_W-1:0] ALL1 = {CNT_W{1'b1}};

  logic [CNT_W-1:0] nxt;
  logic             wrap, going_up, tog;

  assign active   = start && tick;
  assign going_up = (cfg.mode == MD_EVENT) && up;

  always_comb begin
    nxt  = count;
    wrap = 1'b0;
    if (active) begin
      if (going_up) begin
        if (count == ALL1) begin
          wrap = 1'b1;
          nxt  = reload;
        end else begin
          nxt = f_inc(count);
        end
      end else if (count == '0) begin
        wrap = 1'b1;
        nxt  = (cfg.mode == MD_PWM) ? ALL1 : reload;
      end else begin
        nxt = f_dec(count);
      end
    end else begin
      if (ld_full) nxt = ALL1;
      if (ld_lo)   nxt[BYTE_W-1:0] = ld_byte;
      if (ld_hi)   nxt[CNT_W-1:BYTE_W] = ld_byte;
    end
  end

  assign stop_req = wrap && (cfg.mode == MD_ONESHOT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      ovf   <= 1'b0;
      tog   <= 1'b0;
      irq   <= 1'b0;
    end else begin
      count <= nxt;
      ovf   <= wrap;
      tog   <= tog ^ wrap;
      irq   <= wrap | (irq & ~irq_clr);
    end
  end

  assign pulse_out = (cfg.mode == MD_PWM) ? f_pwm_level(count, reload, start) : tog;

  AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !ld_lo && !ld_hi && !ld_full) |=> $stable(count)); // R3
  AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !going_up && count != '0) |=> count == CNT_W'($past(count) - CNT_W'(1))); // R4
  AST_COUNT_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (active && going_up && count != ALL1) |=> count == CNT_W'($past(count) + CNT_W'(1))); // R8
  AST_PWM_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && cfg.mode == MD_PWM && $past(cfg.mode) == MD_PWM) |-> count == ALL1); // R11
endmodule

// File: rtl/mtimer_chan.sv
module mtimer_chan
  import mtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [N_CLK-1:0]  tick_en,
  input  logic              pin_in,
  input  logic              prev_ovf,
  input  logic              next_ovf,
  input  logic              grp_ovf,
  output logic [CNT_W-1:0]  count_val,
  output logic              ovf_pulse,
  output logic              irq,
  output logic              pulse_out
);
  cfg_t             cfg;
  logic [CNT_W-1:0] reload;
  logic start, up, irq_clr, ld_lo, ld_hi, ld_full;
  logic tick, pin_s, stop_req, active;

  mtc_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .stop_req(stop_req), .cfg(cfg), .reload(reload), .start(start), .up(up),
    .irq_clr(irq_clr), .ld_lo(ld_lo), .ld_hi(ld_hi), .ld_full(ld_full)
  );

  mtc_src u_src (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .tick_en(tick_en), .pin_in(pin_in),
    .prev_ovf(prev_ovf), .next_ovf(next_ovf), .grp_ovf(grp_ovf),
    .tick(tick), .pin_s(pin_s)
  );

  mtc_core u_core (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .reload(reload), .start(start), .up(up),
    .tick(tick), .irq_clr(irq_clr), .ld_lo(ld_lo), .ld_hi(ld_hi), .ld_full(ld_full),
    .ld_byte(wr_data), .count(count_val), .ovf(ovf_pulse), .irq(irq),
    .pulse_out(pulse_out), .stop_req(stop_req), .active(active)
  );

  AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(stop_req) && !$past(wr_en && wr_addr == 2'd3)) |-> !start); // R9
  AST_IRQ_ON_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |-> irq); // R5
  AST_OVF_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |-> $past(active)); // R5
  AST_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_pulse && cfg.mode != MD_PWM && $past(cfg.mode) != MD_PWM)
      |-> pulse_out != $past(pulse_out)); // R10
  AST_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.mode == MD_TIMER && cfg.gate && !pin_s) |-> !tick); // R6
endmodule

// File: tb/mtimer_chan_bench.sv
module mtimer_chan_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [3:0]  tick_en = '0;
  logic        pin_in = 1'b0, prev_ovf = 1'b0, next_ovf = 1'b0, grp_ovf = 1'b0;
  logic [15:0] count_val;
  logic        ovf_pulse, irq, pulse_out;

  int checks = 0, failures = 0, cyc = 0, novf = 0;
  bit done = 0;

  always #10 clk = ~clk;

  mtimer_chan u_mtimer_chan (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .tick_en(tick_en), .pin_in(pin_in), .prev_ovf(prev_ovf), .next_ovf(next_ovf),
    .grp_ovf(grp_ovf), .count_val(count_val), .ovf_pulse(ovf_pulse), .irq(irq),
    .pulse_out(pulse_out)
  );

  // behavioural reference model
  int m_count = 0, m_reload = 0, m_cfg = 0;
  bit m_start = 0, m_up = 0, m_irq = 0, m_ovf = 0, m_tog = 0;
  bit m_s1 = 0, m_s2 = 0, m_pd = 0;

  function automatic bit m_pulse();
    if ((m_cfg & 3) == 3) return m_start && ((65535 - m_count) < m_reload);
    return m_tog;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_count = 0; m_reload = 0; m_cfg = 0; m_start = 0; m_up = 0;
      m_irq = 0; m_ovf = 0; m_tog = 0; m_s1 = 0; m_s2 = 0; m_pd = 0;
    end else begin
      int md, src;
      bit ev, act, wrapped, nstart;
      int ncount;
      md = m_cfg & 3;
      if (md == 1) begin
        src = (m_cfg >> 4) & 3;
        if (src == 0) ev = ((m_cfg >> 6) & 1) ? (!m_s2 && m_pd) : (m_s2 && !m_pd);
        else if (src == 1) ev = prev_ovf;
        else if (src == 2) ev = next_ovf;
        else ev = grp_ovf;
      end else begin
        ev = tick_en[(m_cfg >> 2) & 3] && (md != 0 || ((m_cfg >> 7) & 1) == 0 || m_s2);
      end
      act = m_start && ev;
      wrapped = 0; nstart = m_start; ncount = m_count;
      if (act) begin
        if (md == 1 && m_up) begin
          if (m_count == 65535) begin wrapped = 1; ncount = m_reload; end
          else ncount = m_count + 1;
        end else if (m_count == 0) begin
          wrapped = 1;
          ncount = (md == 3) ? 65535 : m_reload;
          if (md == 2) nstart = 0;
        end else ncount = m_count - 1;
      end
      m_irq = wrapped || (m_irq && !(wr_en && wr_addr == 3 && wr_data[2]));
      if (wr_en) begin
        case (wr_addr)
          2'd0: begin
            m_reload = (m_reload & 16'hFF00) | wr_data;
            if (!m_start) ncount = (ncount & 16'hFF00) | wr_data;
          end
          2'd1: begin
            m_reload = (m_reload & 16'h00FF) | (int'(wr_data) << 8);
            if (!m_start) ncount = (ncount & 16'h00FF) | (int'(wr_data) << 8);
          end
          2'd2: m_cfg = wr_data;
          default: begin
            if (wr_data[0] && !m_start && md == 3) ncount = 65535;
            nstart = wr_data[0];
            m_up = wr_data[1];
          end
        endcase
      end
      m_count = ncount; m_start = nstart; m_ovf = wrapped;
      if (wrapped) m_tog = !m_tog;
      m_pd = m_s2; m_s2 = m_s1; m_s1 = pin_in;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // every-cycle comparison and stimulus clock enables
  always @(negedge clk) begin
    cyc++;
    tick_en <= {cyc % 64 == 0, cyc % 32 == 0, cyc % 8 == 0, 1'b1};
    if (ovf_pulse) novf++;
    if (rst_n && !done) begin
      string tag;
      case (m_cfg & 3)
        0: tag = "R4 model";
        1: tag = "R7 model";
        2: tag = "R9 model";
        default: tag = "R11 model";
      endcase
      chk(tag, {count_val, ovf_pulse, irq, pulse_out},
          {m_count[15:0], m_ovf, m_irq, m_pulse()});
    end
    if (cyc > 180000 && !done) begin
      done = 1;
      failures++; checks++;
      $display("FAIL watchdog actual=%0d expected<180000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse(input int which, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (which == 0) prev_ovf = 1; else if (which == 1) next_ovf = 1; else grp_ovf = 1;
      @(negedge clk);
      prev_ovf = 0; next_ovf = 0; grp_ovf = 0;
      @(negedge clk);
    end
  endtask

  task automatic pin_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      idle(2); pin_in = 1; idle(2); pin_in = 0;
    end
    idle(5);
  endtask

  initial begin
    logic [15:0] snap;
    idle(3);
    rst_n = 1;
    @(negedge clk);
    chk("R1 count", count_val, 0);
    chk("R1 outs", {ovf_pulse, irq, pulse_out}, 0);

    // timer mode, write-through while stopped
    wr(0, 8'h05); wr(1, 8'h00);
    chk("R2 write-through", count_val, 16'h0005);
    wr(2, 8'h00); wr(3, 8'h01);
    idle(20);
    chk("R5 irq set", irq, 1);
    chk("R10 toggle parity", pulse_out, novf % 2);
    wr(3, 8'h04);
    chk("R5 irq clear", irq, m_irq);
    snap = count_val;
    idle(10);
    chk("R3 hold", count_val, snap);

    // clock enable selection
    for (int s = 1; s < 4; s++) begin
      wr(2, 8'(s << 2)); wr(3, 8'h01);
      idle(70);
      chk("R4 csel", count_val, m_count);
      wr(3, 8'h04);
    end

    // gate
    wr(2, 8'h80); pin_in = 0; idle(4);
    wr(3, 8'h01);
    snap = count_val; idle(10);
    chk("R6 gated off", count_val, snap);
    pin_in = 1; idle(12);
    chk("R6 gated on", count_val, m_count);
    pin_in = 0; idle(4);
    wr(3, 8'h00);

    // event counter
    wr(0, 8'h0A); wr(1, 8'h00);
    wr(2, 8'h01); wr(3, 8'h01);
    pin_pulses(3);
    chk("R7 rising", count_val, 16'd7);
    wr(2, 8'h41);
    pin_pulses(2);
    chk("R7 falling", count_val, 16'd5);
    wr(2, 8'h11);
    pulse(0, 3); pulse(1, 2);
    chk("R7 prev", count_val, 16'd2);
    wr(2, 8'h21);
    pulse(1, 1); pulse(2, 2);
    chk("R7 next", count_val, 16'd1);
    wr(2, 8'h31);
    pulse(2, 1);
    chk("R7 group", count_val, 16'd0);

    // up count and overflow
    wr(3, 8'h04);
    wr(0, 8'hFE); wr(1, 8'hFF);
    chk("R2 hi byte", count_val, 16'hFFFE);
    wr(3, 8'h03);
    pulse(2, 1);
    chk("R8 up", count_val, 16'hFFFF);
    pulse(2, 1);
    chk("R8 overflow reload", count_val, 16'hFFFE);
    chk("R5 irq after up", irq, 1);
    chk("R10 parity", pulse_out, novf % 2);
    wr(3, 8'h04);

    // one-shot
    wr(0, 8'h03); wr(1, 8'h00);
    wr(2, 8'h02); wr(3, 8'h01);
    idle(12);
    chk("R9 stopped at reload", count_val, 16'h0003);
    idle(8);
    chk("R9 still held", count_val, 16'h0003);

    // PWM
    wr(3, 8'h04);
    wr(0, 8'h04); wr(1, 8'h00);
    wr(2, 8'h03); wr(3, 8'h01);
    chk("R11 arm", count_val, 16'hFFFF);
    chk("R11 high", pulse_out, 1);
    idle(4);
    chk("R11 low", pulse_out, 0);
    begin
      int lim = 0;
      while (!ovf_pulse && lim < 70000) begin @(negedge clk); lim++; end
    end
    chk("R11 wrap", count_val, 16'hFFFF);
    chk("R11 pulse", ovf_pulse, 1);
    chk("R11 high again", pulse_out, 1);
    idle(3);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule